// File: doc/BRIEF.md
# Replay FIFO with Half-Full Flag

A single-clock first-in first-out buffer for 9-bit words with a power-of-two depth set by a parameter (16 by default). Writes and reads are requested by active-low strobes that the block samples on the rising clock edge. It reports its fill state on three active-low flags: empty, full and more-than-half-full. Requests that would overflow a full buffer, or underflow an empty one, are dropped.

An active-low replay input moves the read position back to storage slot zero. Everything written since the last reset can then be read again, followed by any words written after the replay. The occupancy is recomputed from the write position, so all three flags stay correct.

The read data bus behaves like a three-state output. It is modelled as an output-enable plus a data bus that reads zero while the enable is low. Reset is synchronous and active low. It overrides replay, and replay overrides the read and write strobes.

Top module: `replay_fifo`

## Requirements
- R1: A clock edge with `rst_n` low leaves `empty_n`=0, `full_n`=1, `half_n`=1 and `q_oe`=0.
- R2: Words are read out in the order they were written. Each accepted read puts the oldest word on `q` with `q_oe`=1 after that same edge.
- R3: A write requested while the buffer holds DEPTH words is dropped. Nothing is stored and `full_n` stays 0.
- R4: A read requested while the buffer is empty is dropped. `q_oe` stays 0 and `empty_n` stays 0.
- R5: `half_n` is 0 exactly when the stored count exceeds DEPTH/2. It goes low on the write that makes the count DEPTH/2+1, and back high on the read that makes it DEPTH/2.
- R6: `full_n` is 0 exactly when the count equals DEPTH. One read from a full buffer returns it to 1.
- R7: `empty_n` is 0 exactly when the count is zero. The first write into an empty buffer sets it to 1.
- R8: A clock edge with `rtx_n` low sets the read position to slot 0 and the count to the number of writes since reset, for up to DEPTH writes. Later reads return those words again from the first one, and the flags follow the new count.
- R9: Words written after a replay are read out after the replayed words.
- R10: During a replay edge, read and write strobes have no effect.
- R11: With the buffer neither empty nor full, a simultaneous read and write both take effect and leave all three flags unchanged.
- R12: `q_oe` is 1 only in the cycle after an accepted read. At all other times it is 0 and `q` reads 0.
- R13: Reset has priority over a replay requested on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rtx_n | input | 1 | Replay request, active low |
| din | input | 9 | Write data |
| q | output | 9 | Read data, zero when not enabled |
| q_oe | output | 1 | Read data enable |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |

## Verification
Two functions can fall on the same edge. The first pair is a read and a write together. The bench drives both strobes low on a partly filled buffer and judges the result from the unchanged flags and from the order of the words read later. The second pair is a replay against the data strobes. The bench holds both strobes low during a replay edge and expects the count to equal the write total. A scoreboard queue fed by the driver model then compares every replayed word.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
   // accepted operations for one clock edge
   typedef struct packed {
      logic clear;
      logic rewind;
      logic push;
      logic pop;
   } rfifo_op_t;
endpackage

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_n,
   input  logic                  rd_n,
   input  logic                  rtx_n,
   output rfifo_pkg::rfifo_op_t  op,
   output logic [AW-1:0]         waddr,
   output logic [AW-1:0]         raddr,
   output logic [AW:0]           count
);
   localparam logic [AW:0] FULLCNT = (AW+1)'(DEPTH);

   logic [AW:0]   wptr;
   logic [AW-1:0] rptr;

   // priority: reset, then rewind, then data strobes
   always_comb begin
      op.clear  = !rst_n;
      op.rewind = rst_n && !rtx_n;
      op.push   = rst_n && rtx_n && !wr_n && (count != FULLCNT);
      op.pop    = rst_n && rtx_n && !rd_n && (count != '0);
   end

   always_ff @(posedge clk) begin
      if (op.clear) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (op.rewind) begin
         rptr  <= '0;
         count <= wptr - (AW+1)'(0);
      end else begin
         if (op.push) wptr <= wptr + 1'b1;
         if (op.pop)  rptr <= rptr + 1'b1;
         count <= count + (AW+1)'(op.push) - (AW+1)'(op.pop);
      end
   end

   assign waddr = wptr[AW-1:0];
   assign raddr = rptr;
endmodule

// File: rtl/rfifo_store.sv
module rfifo_store #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  rfifo_pkg::rfifo_op_t op,
   input  logic [AW-1:0]        waddr,
   input  logic [AW-1:0]        raddr,
   input  logic [WIDTH-1:0]     din,
   output logic [WIDTH-1:0]     q,
   output logic                 q_oe
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] q_r;
   logic             oe_r;

   always_ff @(posedge clk) begin
      if (op.push) mem[waddr] <= din;
   end

   always_ff @(posedge clk) begin
      if (op.clear) oe_r <= 1'b0;
      else          oe_r <= op.pop;
      if (op.pop)   q_r  <= mem[raddr];
   end

   assign q_oe = oe_r;
   assign q    = oe_r ? q_r : '0;
endmodule

// File: rtl/rfifo_flags.sv
module rfifo_flags #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic [AW:0] count,
   output logic        empty_n,
   output logic        full_n,
   output logic        half_n
);
   localparam logic [AW:0] FULLCNT = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALFCNT = (AW+1)'(DEPTH / 2);

   assign empty_n = (count != '0);
   assign full_n  = (count != FULLCNT);
   assign half_n  = !(count > HALFCNT);
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic             rtx_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             q_oe,
   output logic             empty_n,
   output logic             full_n,
   output logic             half_n
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("replay_fifo: DEPTH must be a power of two, at least 4");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("replay_fifo: WIDTH must be positive");
      end
   endgenerate

   rfifo_pkg::rfifo_op_t op;
   logic [AW-1:0] waddr, raddr;
   logic [AW:0]   count;

   rfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
      .op(op), .waddr(waddr), .raddr(raddr), .count(count)
   );

   rfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk(clk), .op(op), .waddr(waddr), .raddr(raddr), .din(din),
      .q(q), .q_oe(q_oe)
   );

   rfifo_flags #(.DEPTH(DEPTH)) u_flags (
      .count(count), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );
endmodule

// File: rtl/rfifo_chk.sv
module rfifo_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_n,
   input logic rd_n,
   input logic rtx_n,
   input logic q_oe,
   input logic empty_n,
   input logic full_n,
   input logic half_n
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (!empty_n && full_n && half_n && !q_oe));

   // R4
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rtx_n && !empty_n) |=> !q_oe);

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rtx_n && !full_n && !wr_n && rd_n) |=> !full_n);

   // R6
   full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> (!half_n && empty_n));

   // R11
   rdwr_flags_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rtx_n && empty_n && full_n && !rd_n && !wr_n)
      |=> $stable({empty_n, full_n, half_n}));

   // R12
   oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_oe |-> $past(rst_n && rtx_n && !rd_n && empty_n));
endmodule

bind replay_fifo rfifo_chk u_rfifo_chk (
   .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
   .q_oe(q_oe), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
);

// File: tb/replay_fifo_bench.sv
`timescale 1ns/1ps
module replay_fifo_bench;
   localparam int DEPTH = 16;
   localparam int W     = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, rtx_n = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] q;
   logic q_oe, empty_n, full_n, half_n;

   always #10 clk = ~clk;

   replay_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_replay_fifo (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
      .din(din), .q(q), .q_oe(q_oe),
      .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
   );

   int compared = 0, mismatched = 0;
   logic [W-1:0] exp_q[$];
   logic [W-1:0] mmem [DEPTH];
   int mwp = 0, mrp = 0, mcnt = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   // driver: one clock edge of stimulus plus the reference model update
   task automatic step(input bit w, input bit r, input bit t, input int d, input bit rs = 1'b1);
      bit wok, rok;
      @(negedge clk);
      wr_n = !w; rd_n = !r; rtx_n = !t; din = W'(d); rst_n = rs;
      if (!rs) begin
         mwp = 0; mrp = 0; mcnt = 0; exp_q.delete();
      end else if (t) begin
         mrp = 0; mcnt = mwp;
      end else begin
         wok = w && (mcnt != DEPTH);
         rok = r && (mcnt != 0);
         if (rok) begin
            exp_q.push_back(mmem[mrp]);
            mrp = (mrp + 1) % DEPTH;
         end
         if (wok) begin
            mmem[mwp % DEPTH] = W'(d);
            mwp = (mwp + 1) % (2 * DEPTH);
         end
         mcnt = mcnt + int'(wok) - int'(rok);
      end
   endtask

   task automatic look;
      @(posedge clk); #2;
   endtask

   // monitor: data (R2/R12) and flags (R5/R6/R7) after every edge
   always @(posedge clk) begin
      #5;
      if (q_oe) begin
         if (exp_q.size() == 0) chk(1'b0, "R12 unexpected q_oe", 1, 0);
         else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            chk(q == e, "R2 read data", int'(q), int'(e));
         end
      end else begin
         if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            chk(1'b0, "R12 missing q_oe", 0, 1);
         end
         chk(q == '0, "R12 idle bus", int'(q), 0);
      end
      if (rst_n) begin
         chk(empty_n == (mcnt != 0), "R7 empty_n", int'(empty_n), int'(mcnt != 0));
         chk(full_n == (mcnt != DEPTH), "R6 full_n", int'(full_n), int'(mcnt != DEPTH));
         chk(half_n == !(mcnt > DEPTH/2), "R5 half_n", int'(half_n), int'(!(mcnt > DEPTH/2)));
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      step(0, 0, 0, 0, 0); look;
      chk(!empty_n && full_n && half_n && !q_oe, "R1 reset flags",
          {empty_n, full_n, half_n, q_oe}, 4'b0110);
      // R4 read on empty is dropped
      step(0, 1, 0, 0); look;
      chk(!q_oe && !empty_n, "R4 read on empty", {q_oe, empty_n}, 0);
      // R7 first write clears empty
      step(1, 0, 0, 'h101); look;
      chk(empty_n == 1'b1, "R7 empty_n after first write", empty_n, 1);
      for (int i = 1; i < DEPTH/2; i++) step(1, 0, 0, 'h100 + i);
      look;
      chk(half_n == 1'b1, "R5 half_n at half", half_n, 1);
      step(1, 0, 0, 'h1F0); look;
      chk(half_n == 1'b0, "R5 half_n at half plus one", half_n, 0);
      step(0, 1, 0, 0); look;
      chk(half_n == 1'b1, "R5 half_n back at half", half_n, 1);
      for (int i = 0; i < DEPTH/2; i++) step(1, 0, 0, 'h040 + i);
      look;
      chk(full_n == 1'b0, "R6 full_n at depth", full_n, 0);
      // R3 write on full dropped
      step(1, 0, 0, 'h1AA); look;
      chk(full_n == 1'b0, "R3 full_n held", full_n, 0);
      step(0, 1, 0, 0); look;
      chk(full_n == 1'b1, "R6 full_n after one read", full_n, 1);
      // R11 simultaneous read and write
      step(1, 1, 0, 'h0C3); look;
      chk(full_n && !half_n && empty_n, "R11 flags after rd+wr",
          {empty_n, full_n, half_n}, 3'b110);
      for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0, 0);
      look;
      chk(!empty_n, "R3 drained without stray word", empty_n, 0);

      // R8 / R9 / R10 replay
      step(0, 0, 0, 0, 0);
      for (int i = 0; i < 5; i++) step(1, 0, 0, 'h0A0 + i);
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
      step(1, 1, 1, 'h155); look;
      chk(empty_n && half_n && !q_oe, "R10 strobes ignored on replay",
          {empty_n, half_n, q_oe}, 3'b110);
      step(1, 0, 0, 'h0B5);
      step(1, 0, 0, 'h0B6); look;
      chk(empty_n, "R8 count restored", empty_n, 1);
      for (int i = 0; i < 8; i++) step(0, 1, 0, 0);
      look;
      chk(!empty_n, "R9 replay plus new words drained", empty_n, 0);

      // R8 full-depth replay recomputes full flag
      step(0, 0, 0, 0, 0);
      for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 'h011 * i + 3);
      for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0);
      step(0, 0, 1, 0); look;
      chk(!full_n && !half_n, "R8 full after replay", {full_n, half_n}, 0);
      for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0);
      look;
      chk(!empty_n, "R8 replayed all words", empty_n, 0);

      // R13 reset wins over replay
      for (int i = 0; i < 4; i++) step(1, 0, 0, 'h077 + i);
      step(0, 0, 1, 0, 0); look;
      chk(!empty_n && full_n && half_n, "R13 reset over replay",
          {empty_n, full_n, half_n}, 3'b011);
      step(0, 1, 0, 0); look;
      chk(!q_oe, "R13 nothing to read after reset", q_oe, 0);

      step(0, 0, 0, 0); look;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule